// File: doc/BRIEF.md
# Eight-bit waveform timer with one compare channel

This block is an up/up-down counter, `W` bits wide (eight by default), with one compare register and one waveform output. It advances only on cycles where the prescaled `tick` input is high, so the clock divider lives outside. A small write port sets the operating mode, the output action, the compare value and the flag clears. The block offers four modes: a free-running up counter, a symmetric up/down PWM, a counter that restarts when it equals the compare value, and a single-slope PWM.

Each mode has its own turning point, its own moment for loading a newly written compare value into the active register, and its own step for raising the overflow flag. The waveform latch can replace the ordinary port value on the pin. The pin is driven only while the external direction-enable input is high.

Top module: `wavetimer8`

## Requirements
- R1: A synchronous high `rst` clears the counter, the active and pending compare values, the waveform latch, the mode and action fields and both flags, and sets the count direction to up.
- R2: The counter changes only on cycles with `tick` high. In mode 0 (free-running) and mode 3 (single-slope PWM) it counts up by one and wraps from all-ones to zero.
- R3: In mode 1 (up/down PWM) the counter climbs from 0 to all-ones, steps down to all-ones minus one on the next tick, and falls back to 0. On the tick taken at 0 while falling it turns and goes to 1.
- R4: In mode 2 (restart on compare) a tick taken while the counter equals the active compare value sends it to 0. Any other tick adds one, wrapping at all-ones.
- R5: Writing address 1 stores `wr_data` as the pending compare value. In modes 0 and 2 the active compare value `cmp_o` takes it on the same edge.
- R6: In mode 1 the active compare value loads the pending one on the tick taken at all-ones (TOP). In mode 3 it loads on the tick that wraps the counter to zero. Writes at other times leave `cmp_o` unchanged.
- R7: `ovf_flag_o` sets on a tick taken at all-ones in modes 0, 2 and 3. In mode 1 it sets on the tick taken at 0 while counting down.
- R8: `cmp_flag_o` sets on any tick taken while the counter equals `cmp_o`. Writing address 3 clears the overflow flag if bit 0 is 1 and the compare flag if bit 1 is 1. A 0 bit leaves its flag unchanged. A set in the same cycle wins over a clear.
- R9: In modes 0 and 2 a compare-match tick applies the action field: 1 toggles the latch, 2 clears it, 3 sets it, and 0 leaves it alone.
- R10: In mode 3, action 2 clears the latch on a match and sets it at the wrap to zero. Action 3 does the opposite. The wrap action applies alone when the compare value is all-ones. Action 1 is reserved and does nothing.
- R11: In mode 1, action 2 clears the latch on a match while counting up and sets it on a match while counting down. Action 3 does the opposite, and action 1 is reserved.
- R12: `pin_out` carries the waveform latch when the action field is nonzero, except for action 1 in modes 1 and 3, where it carries `port_val`. `pin_oe` always equals `pin_dir_en`.
- R13: Writing address 0 sets the mode from bits 1:0 and the action from bits 3:2 of `wr_data`. Address 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | W | Write data |
| port_val | input | 1 | Ordinary port value used when the waveform is disconnected |
| pin_dir_en | input | 1 | Pin direction enable |
| pin_out | output | 1 | Value presented to the pin |
| pin_oe | output | 1 | Pin driver enable |
| wave_o | output | 1 | Waveform latch |
| count_o | output | W | Counter value |
| cmp_o | output | W | Active compare value |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare-match flag |

## Verification
A wrong count direction or a missed restart shows on `count_o` at the next tick. In the up/down mode it also moves every later compare match by a full slope, and the bench sees this as a waveform edge hundreds of ticks off. A compare value loaded at the wrong moment shows on `cmp_o` one edge after the write, long before the buffered load was due. A latch left in the wrong state after a wrap or match shows on `wave_o` and `pin_out` within one tick.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;

    typedef enum logic [1:0] {
        WM_FREE  = 2'd0,
        WM_UPDN  = 2'd1,
        WM_RESTART = 2'd2,
        WM_SLOPE = 2'd3
    } wmode_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_CMP   = 2'd1;
    localparam logic [1:0] ADDR_FLAGS = 2'd3;

    localparam int FLG_OVF_BIT = 0;
    localparam int FLG_CMP_BIT = 1;

endpackage

// File: rtl/wtmr_counter.sv
module wtmr_counter
    import wtmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  wmode_e       mode,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt,
    output logic         dir_down,
    output logic         step_at_max,
    output logic         step_bottom_turn,
    output logic         match_step
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            case (mode)
                WM_UPDN: begin
                    if (!st_q.down) begin
                        if (st_q.cnt == CNT_MAX) begin
                            st_d.cnt  = CNT_MAX - CNT_ONE;
                            st_d.down = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + CNT_ONE;
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            st_d.cnt  = CNT_ONE;
                            st_d.down = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt - CNT_ONE;
                        end
                    end
                end
                WM_RESTART: begin
                    if (st_q.cnt == cmp_val) st_d.cnt = '0;
                    else                     st_d.cnt = st_q.cnt + CNT_ONE;
                end
                default: st_d.cnt = st_q.cnt + CNT_ONE;
            endcase
        end
        if (mode != WM_UPDN) st_d.down = 1'b0;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt              = st_q.cnt;
    assign dir_down         = st_q.down;
    assign step_at_max      = tick && (st_q.cnt == CNT_MAX);
    assign step_bottom_turn = tick && (mode == WM_UPDN) && st_q.down && (st_q.cnt == '0);
    assign match_step       = tick && (st_q.cnt == cmp_val);

endmodule

// File: rtl/wtmr_cmpreg.sv
module wtmr_cmpreg
    import wtmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  wmode_e       mode,
    input  logic         wr_cmp,
    input  logic [W-1:0] wr_val,
    input  logic         step_at_max,
    output logic [W-1:0] active
);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] act;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       immediate;
    logic       buffered_load;

    always_comb begin
        immediate     = (mode == WM_FREE) || (mode == WM_RESTART);
        buffered_load = step_at_max && ((mode == WM_UPDN) || (mode == WM_SLOPE));
        st_d = st_q;
        if (buffered_load) st_d.act = st_q.pend;
        if (wr_cmp) begin
            st_d.pend = wr_val;
            if (immediate) st_d.act = wr_val;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign active = st_q.act;

endmodule

// File: rtl/wtmr_wave.sv
module wtmr_wave
    import wtmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wmode_e     mode,
    input  logic [1:0] action,
    input  logic       match_step,
    input  logic       wrap_step,
    input  logic       dir_down,
    input  logic       cmp_is_max,
    output logic       wave
);

    typedef struct packed {
        logic lvl;
    } wave_state_t;

    wave_state_t st_d, st_q;
    logic        slope_match;

    always_comb begin
        st_d        = st_q;
        slope_match = match_step && !cmp_is_max;
        case (mode)
            WM_FREE, WM_RESTART: begin
                if (match_step) begin
                    case (action)
                        2'd1:    st_d.lvl = ~st_q.lvl;
                        2'd2:    st_d.lvl = 1'b0;
                        2'd3:    st_d.lvl = 1'b1;
                        default: st_d.lvl = st_q.lvl;
                    endcase
                end
            end
            WM_SLOPE: begin
                if (action[1]) begin
                    if (wrap_step)        st_d.lvl = ~action[0];
                    else if (slope_match) st_d.lvl = action[0];
                end
            end
            default: begin
                if (action[1] && match_step)
                    st_d.lvl = dir_down ? ~action[0] : action[0];
            end
        endcase
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wave = st_q.lvl;

endmodule

// File: rtl/wavetimer8.sv
module wavetimer8
    import wtmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         port_val,
    input  logic         pin_dir_en,
    output logic         pin_out,
    output logic         pin_oe,
    output logic         wave_o,
    output logic [W-1:0] count_o,
    output logic [W-1:0] cmp_o,
    output logic         ovf_flag_o,
    output logic         cmp_flag_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        wmode_e     mode;
        logic [1:0] action;
        logic       ovf;
        logic       cmpf;
    } top_state_t;

    top_state_t st_d, st_q;

    wmode_e     mode_cur;
    logic [1:0] action_cur;
    logic       dir_down;
    logic       step_at_max;
    logic       step_bottom_turn;
    logic       match_step;
    logic       wr_cmp;
    logic       ovf_event;
    logic       disconnected;

    assign mode_cur   = st_q.mode;
    assign action_cur = st_q.action;
    assign wr_cmp     = wr_en && (wr_addr == ADDR_CMP);

    wtmr_counter #(.W(W)) u_cnt (
        .clk              (clk),
        .rst              (rst),
        .tick             (tick),
        .mode             (mode_cur),
        .cmp_val          (cmp_o),
        .cnt              (count_o),
        .dir_down         (dir_down),
        .step_at_max      (step_at_max),
        .step_bottom_turn (step_bottom_turn),
        .match_step       (match_step)
    );

    wtmr_cmpreg #(.W(W)) u_cmp (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode_cur),
        .wr_cmp      (wr_cmp),
        .wr_val      (wr_data),
        .step_at_max (step_at_max),
        .active      (cmp_o)
    );

    wtmr_wave u_wave (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_cur),
        .action     (action_cur),
        .match_step (match_step),
        .wrap_step  (step_at_max),
        .dir_down   (dir_down),
        .cmp_is_max (cmp_o == CNT_MAX),
        .wave       (wave_o)
    );

    always_comb begin
        st_d      = st_q;
        ovf_event = (mode_cur == WM_UPDN) ? step_bottom_turn : step_at_max;
        if (wr_en && (wr_addr == ADDR_CTRL)) begin
            st_d.mode   = wmode_e'(wr_data[1:0]);
            st_d.action = wr_data[3:2];
        end
        if (wr_en && (wr_addr == ADDR_FLAGS)) begin
            if (wr_data[FLG_OVF_BIT]) st_d.ovf  = 1'b0;
            if (wr_data[FLG_CMP_BIT]) st_d.cmpf = 1'b0;
        end
        if (ovf_event)  st_d.ovf  = 1'b1;
        if (match_step) st_d.cmpf = 1'b1;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        disconnected = (action_cur == 2'd0) ||
                       ((action_cur == 2'd1) &&
                        ((mode_cur == WM_UPDN) || (mode_cur == WM_SLOPE)));
        pin_out = disconnected ? port_val : wave_o;
        pin_oe  = pin_dir_en;
    end

    assign ovf_flag_o = st_q.ovf;
    assign cmp_flag_o = st_q.cmpf;

endmodule

// File: rtl/wtmr_checker.sv
module wtmr_checker
    import wtmr_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input wmode_e       mode,
    input logic [1:0]   action,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp,
    input logic         ovf,
    input logic         wave,
    input logic         dir_down
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    assert_updn_turn_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == WM_UPDN && tick && cnt == CNT_MAX && !dir_down)
        |=> (cnt == CNT_MAX - W'(1)) && dir_down);

    assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == WM_RESTART && tick && cnt == cmp) |=> cnt == '0);

    assert_slope_cmp_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == WM_SLOPE && !(tick && cnt == CNT_MAX)) |=> $stable(cmp));

    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
        (mode != WM_UPDN && tick && cnt == CNT_MAX) |=> ovf);

    assert_slope_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == WM_SLOPE && action == 2'd2 && tick && cnt == CNT_MAX) |=> wave);

endmodule

bind wavetimer8 wtmr_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .mode     (mode_cur),
    .action   (action_cur),
    .cnt      (count_o),
    .cmp      (cmp_o),
    .ovf      (ovf_flag_o),
    .wave     (wave_o),
    .dir_down (dir_down)
);

// File: tb/sim_wavetimer8.sv
module sim_wavetimer8;

    localparam int CLK_NS = 20;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         port_val = 1'b0;
    logic         pin_dir_en = 1'b0;
    logic         pin_out, pin_oe, wave_o, ovf_flag_o, cmp_flag_o;
    logic [W-1:0] count_o, cmp_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    wavetimer8 #(.W(W)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .port_val(port_val), .pin_dir_en(pin_dir_en),
        .pin_out(pin_out), .pin_oe(pin_oe), .wave_o(wave_o), .count_o(count_o),
        .cmp_o(cmp_o), .ovf_flag_o(ovf_flag_o), .cmp_flag_o(cmp_flag_o)
    );

    // fields: [28:27] mode, [26:19] compare, [18:9] ticks, [8:1] count, [0] ovf
    localparam int NV = 12;
    localparam logic [28:0] VEC [NV] = '{
        {2'd0, 8'd0,   10'd10,  8'd10,  1'b0},
        {2'd0, 8'd0,   10'd256, 8'd0,   1'b1},
        {2'd0, 8'd0,   10'd300, 8'd44,  1'b1},
        {2'd2, 8'd5,   10'd6,   8'd0,   1'b0},
        {2'd2, 8'd5,   10'd9,   8'd3,   1'b0},
        {2'd2, 8'd0,   10'd3,   8'd0,   1'b0},
        {2'd2, 8'd255, 10'd256, 8'd0,   1'b1},
        {2'd1, 8'd0,   10'd255, 8'd255, 1'b0},
        {2'd1, 8'd0,   10'd300, 8'd210, 1'b0},
        {2'd1, 8'd0,   10'd510, 8'd0,   1'b0},
        {2'd1, 8'd0,   10'd511, 8'd1,   1'b1},
        {2'd3, 8'd0,   10'd256, 8'd0,   1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state after a dirty run
        do_reset();
        wr(2'd0, 8'h0C); wr(2'd1, 8'h03); ticks(300);
        do_reset();
        check("R1 count", count_o, 0);
        check("R1 cmp", cmp_o, 0);
        check("R1 ovf", ovf_flag_o, 0);
        check("R1 cmpf", cmp_flag_o, 0);
        check("R1 wave", wave_o, 0);

        // vector table: R2 R3 R4 R7 R13 counting and overflow per mode
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(2'd0, {6'd0, VEC[i][28:27]});
            wr(2'd1, VEC[i][26:19]);
            ticks(int'(VEC[i][18:9]));
            check($sformatf("R2/R3/R4 vec %0d count", i), count_o, int'(VEC[i][8:1]));
            check($sformatf("R7 vec %0d ovf", i), ovf_flag_o, int'(VEC[i][0]));
        end

        // R2 no tick, no change
        do_reset(); ticks(5);
        repeat (4) @(negedge clk);
        check("R2 hold", count_o, 5);

        // R5 immediate compare load; R13 address 2 has no effect
        do_reset(); wr(2'd0, 8'h02); wr(2'd1, 8'h07);
        check("R5 immediate", cmp_o, 7);
        wr(2'd2, 8'hFF);
        check("R13 addr2 cmp", cmp_o, 7);
        check("R13 addr2 count", count_o, 0);

        // R6 single-slope buffered load at wrap
        do_reset(); wr(2'd0, 8'h03); wr(2'd1, 8'h80);
        check("R6 slope pending", cmp_o, 0);
        ticks(255);
        check("R6 slope before wrap", cmp_o, 0);
        ticks(1);
        check("R6 slope loaded", cmp_o, 8'h80);

        // R6 up/down buffered load at TOP
        do_reset(); wr(2'd0, 8'h01); wr(2'd1, 8'h33);
        ticks(255);
        check("R6 updn before top", cmp_o, 0);
        ticks(1);
        check("R6 updn loaded", cmp_o, 8'h33);
        check("R3 after top", count_o, 254);

        // R8 flags and selective clearing
        do_reset(); wr(2'd0, 8'h00); wr(2'd1, 8'h03);
        ticks(256);
        check("R8 cmpf set", cmp_flag_o, 1);
        check("R7 ovf set", ovf_flag_o, 1);
        wr(2'd3, 8'h02);
        check("R8 cmpf cleared", cmp_flag_o, 0);
        check("R8 ovf kept", ovf_flag_o, 1);
        wr(2'd3, 8'h01);
        check("R8 ovf cleared", ovf_flag_o, 0);

        // R9 non-PWM actions, R12 pin follows latch
        do_reset(); wr(2'd0, 8'h04); wr(2'd1, 8'h02);
        ticks(3);
        check("R9 toggle on", wave_o, 1);
        check("R12 pin latch", pin_out, 1);
        ticks(256);
        check("R9 toggle off", wave_o, 0);
        wr(2'd0, 8'h0C); ticks(256);
        check("R9 set", wave_o, 1);
        wr(2'd0, 8'h08); ticks(256);
        check("R9 clear", wave_o, 0);

        // R10 single-slope non-inverting
        do_reset(); wr(2'd0, 8'h0B); wr(2'd1, 8'h10);
        ticks(256 + 16);
        check("R10 noninv high", wave_o, 1);
        ticks(1);
        check("R10 noninv cleared", wave_o, 0);

        // R10 single-slope inverting
        do_reset(); wr(2'd0, 8'h0F); wr(2'd1, 8'h10);
        ticks(256 + 16);
        check("R10 inv low", wave_o, 0);
        ticks(1);
        check("R10 inv set", wave_o, 1);

        // R10 compare equal to all-ones: match ignored
        do_reset(); wr(2'd0, 8'h0B); wr(2'd1, 8'hFF);
        ticks(256);
        check("R10 top wave", wave_o, 1);
        ticks(255);
        check("R10 top before wrap", wave_o, 1);
        ticks(1);
        check("R10 top after wrap", wave_o, 1);

        // R10 R12 reserved action 1 in single-slope
        do_reset(); port_val = 1'b1; wr(2'd0, 8'h07); wr(2'd1, 8'h10);
        ticks(300);
        check("R10 reserved wave", wave_o, 0);
        check("R12 reserved pin", pin_out, 1);
        port_val = 1'b0; @(negedge clk);
        check("R12 reserved pin low", pin_out, 0);

        // R11 up/down action 2
        do_reset(); wr(2'd0, 8'h09); wr(2'd1, 8'h10);
        ticks(494);
        check("R11 before down match", wave_o, 0);
        ticks(1);
        check("R11 down match set", wave_o, 1);
        ticks(31);
        check("R11 before up match", wave_o, 1);
        ticks(1);
        check("R11 up match clear", wave_o, 0);

        // R12 disconnected pin and driver enable
        do_reset(); port_val = 1'b1; pin_dir_en = 1'b0; @(negedge clk);
        check("R12 pin port", pin_out, 1);
        check("R12 oe off", pin_oe, 0);
        pin_dir_en = 1'b1; @(negedge clk);
        check("R12 oe on", pin_oe, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule